// File: doc/BRIEF.md
# Graph-Aware RRIP Replacement Controller

This block holds the replacement state of one set in a set-associative cache and chooses which way to evict. For every way it keeps a valid flag, a re-reference prediction value (RRPV) and the degree-bucket tier of the line that lives there. Tag lookup, data storage and the computation of future-reference distances all live outside; this block only sees hit notifications, fill notifications carrying the tier of the incoming line, and victim requests.

A fill sets a line's starting RRPV from its tier alone: hot buckets start near zero, cold buckets start just under the maximum. A hit on a line of the hottest bucket pulls its RRPV straight to zero. A hit on any other line only moves it one step toward zero. When a victim is requested, empty ways win outright. Otherwise the set is aged in one step so that at least one line sits at the maximum RRPV, and the lines at the maximum become candidates. Two tiebreak levels then narrow the candidates: coldest tier, and furthest next-reference distance. A run-time mode picks the order of the two levels or drops the distance level. The distances arrive with the request and are only looked at during that cycle.

Top module: `grrip_repl`

## Requirements
- R1: After reset every way is invalid and `vic_valid` is low.
- R2: `vic_valid` is high in exactly the cycle after a cycle with `vic_req` high, and low otherwise; `vic_way` is meaningful while `vic_valid` is high.
- R3: If any way is invalid at the request, the victim is the lowest-indexed invalid way, and no RRPV changes.
- R4: A fill marks the way valid and stores its tier. Tiers above NUM_BKT-1 are clamped to NUM_BKT-1. The starting RRPV is ((NUM_BKT-1-tier)*(MAX-1))/(NUM_BKT-1), with MAX = 2^RRPV_W-1. So tier NUM_BKT-1 (hottest) starts at 0 and tier 0 (coldest) starts at MAX-1.
- R5: A hit on a valid way whose tier is NUM_BKT-1 sets its RRPV to 0. A hit on a valid way with any other tier lowers its RRPV by one, stopping at 0. A hit on an invalid way has no effect, and a fill to the same way in the same cycle takes precedence.
- R6: When all ways are valid, every RRPV is raised by MAX minus the highest RRPV in the set. The raised values are kept, and only ways then at MAX are candidates.
- R7: Mode 0 (and the reserved mode 3) narrows the candidates to the lowest tier value first, then to the largest next-reference distance.
- R8: Mode 1 narrows the candidates to the largest next-reference distance first, then to the lowest tier value.
- R9: Mode 2 narrows the candidates by lowest tier value only; `next_ref` has no effect.
- R10: Any tie left after all levels goes to the lowest-indexed way.
- R11: While `vic_req` is high, `hit_valid` and `fill_valid` in the same cycle are ignored.
- R12: The distance for way i is `next_ref[i*DIST_W +: DIST_W]`, sampled only in the request cycle; a larger value means a later reuse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hit_valid | input | 1 | A hit occurred on `hit_way` |
| hit_way | input | $clog2(WAYS) | Way that hit |
| fill_valid | input | 1 | A line is being installed in `fill_way` |
| fill_way | input | $clog2(WAYS) | Way being filled |
| fill_tier | input | TIER_W | Degree-bucket tier of the incoming line (NUM_BKT-1 is hottest) |
| vic_req | input | 1 | Request a victim this cycle |
| mode | input | 2 | Tiebreak order: 0 tier then distance, 1 distance then tier, 2 tier only, 3 as 0 |
| next_ref | input | WAYS*DIST_W | Per-way next-reference distances for this request |
| vic_valid | output | 1 | Victim result valid |
| vic_way | output | $clog2(WAYS) | Chosen victim way |

## Verification
The bench builds sets where candidates share a tier but differ in distance, and share a distance but differ in tier. A design that applies the levels in the wrong order, or reads `next_ref` in the tier-only mode, names a different way there. Partly filled sets with a hole in the middle catch a design that ages or scans RRPVs before it checks for empty ways. A sequence of repeated requests with non-hot hits in between exposes aged values that are not written back, and a decrement that does not stop at zero. Fills and hits issued in the same cycle as a request show up in later victims if they are not dropped. Mostly equal random distances, a narrow spread of tiers and all four mode codes push the selection into ties that only the lowest-index rule settles.

// File: rtl/grrip_pkg.sv
package grrip_pkg;
   typedef enum logic [1:0] {
      MODE_TIER_FIRST = 2'd0,
      MODE_DIST_FIRST = 2'd1,
      MODE_TIER_ONLY  = 2'd2,
      MODE_RESERVED   = 2'd3
   } grrip_mode_e;
endpackage

// File: rtl/grrip_ins_map.sv
// Maps an incoming tier to its clamped value and starting RRPV.
module grrip_ins_map #(
   parameter int NUM_BKT = 11,
   parameter int TIER_W  = 4,
   parameter int RRPV_W  = 3
) (
   input  logic [TIER_W-1:0] tier_i,
   output logic [TIER_W-1:0] tier_o,
   output logic [RRPV_W-1:0] rrpv_o
);
   localparam int MAXV = (1 << RRPV_W) - 1;
   localparam int TOP  = NUM_BKT - 1;

   generate
      if (NUM_BKT < 2 || NUM_BKT > 16) begin : g_bad_bkt
         $error("NUM_BKT must lie in 2..16");
      end
      if ((1 << TIER_W) < NUM_BKT) begin : g_bad_tw
         $error("TIER_W too narrow for NUM_BKT");
      end
   endgenerate

   int t_clamp;
   int scaled;

   always_comb begin
      t_clamp = (int'(tier_i) > TOP) ? TOP : int'(tier_i);
      scaled  = ((TOP - t_clamp) * (MAXV - 1)) / TOP;
      tier_o  = TIER_W'(t_clamp);
      rrpv_o  = RRPV_W'(scaled);
   end
endmodule

// File: rtl/grrip_way_slot.sv
// State of one way: valid, RRPV and tier.
module grrip_way_slot #(
   parameter int TIER_W = 4,
   parameter int RRPV_W = 3,
   parameter int TOP    = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fill_en,
   input  logic [TIER_W-1:0] fill_tier,
   input  logic [RRPV_W-1:0] fill_rrpv,
   input  logic              hit_en,
   input  logic              age_en,
   input  logic [RRPV_W-1:0] age_delta,
   output logic              valid_o,
   output logic [RRPV_W-1:0] rrpv_o,
   output logic [TIER_W-1:0] tier_o
);
   logic              valid_q;
   logic [RRPV_W-1:0] rrpv_q;
   logic [TIER_W-1:0] tier_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         valid_q <= 1'b0;
         rrpv_q  <= '0;
         tier_q  <= '0;
      end else if (fill_en) begin
         valid_q <= 1'b1;
         rrpv_q  <= fill_rrpv;
         tier_q  <= fill_tier;
      end else if (age_en && valid_q) begin
         rrpv_q  <= rrpv_q + age_delta;
      end else if (hit_en && valid_q) begin
         if (int'(tier_q) == TOP)
            rrpv_q <= '0;
         else if (rrpv_q != '0)
            rrpv_q <= rrpv_q - 1'b1;
      end
   end

   assign valid_o = valid_q;
   assign rrpv_o  = rrpv_q;
   assign tier_o  = tier_q;

   p_fill_store_r4: assert property (@(posedge clk) disable iff (!rst_n)
      fill_en |=> (valid_q && tier_q == $past(fill_tier) && rrpv_q == $past(fill_rrpv)));

   p_hot_hit_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (hit_en && !fill_en && !age_en && valid_q && int'(tier_q) == TOP) |=> (rrpv_q == '0));

   p_cold_hit_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (hit_en && !fill_en && !age_en && valid_q && int'(tier_q) != TOP) |=>
      (rrpv_q == (($past(rrpv_q) == '0) ? '0 : $past(rrpv_q) - 1'b1)));

   p_hit_invalid_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!fill_en && !valid_q) |=> (!valid_q && $stable(rrpv_q)));
endmodule

// File: rtl/grrip_victim_sel.sv
// Combinational victim choice: empty ways, SRRIP aging, layered tiebreaks.
module grrip_victim_sel
   import grrip_pkg::*;
#(
   parameter int WAYS   = 16,
   parameter int TIER_W = 4,
   parameter int RRPV_W = 3,
   parameter int DIST_W = 8,
   localparam int WIX   = (WAYS > 1) ? $clog2(WAYS) : 1
) (
   input  logic [WAYS-1:0]              valid_i,
   input  logic [WAYS-1:0][RRPV_W-1:0]  rrpv_i,
   input  logic [WAYS-1:0][TIER_W-1:0]  tier_i,
   input  logic [WAYS-1:0][DIST_W-1:0]  dist_i,
   input  grrip_mode_e                  mode_i,
   output logic                         all_valid_o,
   output logic [RRPV_W-1:0]            age_delta_o,
   output logic [WIX-1:0]               victim_o
);
   localparam logic [RRPV_W-1:0] MAXV = '1;

   function automatic logic [WAYS-1:0] keep_coldest(
      input logic [WAYS-1:0] m, input logic [WAYS-1:0][TIER_W-1:0] t);
      logic [TIER_W-1:0] lo;
      logic [WAYS-1:0]   r;
      lo = '1;
      for (int i = 0; i < WAYS; i++)
         if (m[i] && t[i] < lo) lo = t[i];
      for (int i = 0; i < WAYS; i++)
         r[i] = m[i] && (t[i] == lo);
      return r;
   endfunction

   function automatic logic [WAYS-1:0] keep_furthest(
      input logic [WAYS-1:0] m, input logic [WAYS-1:0][DIST_W-1:0] d);
      logic [DIST_W-1:0] hi;
      logic [WAYS-1:0]   r;
      hi = '0;
      for (int i = 0; i < WAYS; i++)
         if (m[i] && d[i] > hi) hi = d[i];
      for (int i = 0; i < WAYS; i++)
         r[i] = m[i] && (d[i] == hi);
      return r;
   endfunction

   function automatic logic [WIX-1:0] lowest_set(input logic [WAYS-1:0] m);
      logic [WIX-1:0] idx;
      idx = '0;
      for (int i = WAYS - 1; i >= 0; i--)
         if (m[i]) idx = WIX'(i);
      return idx;
   endfunction

   logic [RRPV_W-1:0] top_rrpv;
   logic [WAYS-1:0]   at_max;
   logic [WAYS-1:0]   narrowed;
   logic [WIX-1:0]    first_empty;

   always_comb begin
      top_rrpv = '0;
      for (int i = 0; i < WAYS; i++)
         if (rrpv_i[i] > top_rrpv) top_rrpv = rrpv_i[i];
      age_delta_o = MAXV - top_rrpv;
      for (int i = 0; i < WAYS; i++)
         at_max[i] = (rrpv_i[i] + age_delta_o) == MAXV;
      unique case (mode_i)
         MODE_DIST_FIRST: narrowed = keep_coldest(keep_furthest(at_max, dist_i), tier_i);
         MODE_TIER_ONLY:  narrowed = keep_coldest(at_max, tier_i);
         default:         narrowed = keep_furthest(keep_coldest(at_max, tier_i), dist_i);
      endcase
      first_empty = lowest_set(~valid_i);
      all_valid_o = &valid_i;
      victim_o    = all_valid_o ? lowest_set(narrowed) : first_empty;
   end

   always_comb begin
      if (all_valid_o) begin
         a_cand_nonempty_r6: assert ($countones(at_max) > 0);
         a_pick_in_cand_r10: assert (at_max[victim_o]);
      end
   end
endmodule

// File: rtl/grrip_repl.sv
module grrip_repl
   import grrip_pkg::*;
#(
   parameter int WAYS    = 16,
   parameter int RRPV_W  = 3,
   parameter int NUM_BKT = 11,
   parameter int TIER_W  = 4,
   parameter int DIST_W  = 8,
   localparam int WIX    = (WAYS > 1) ? $clog2(WAYS) : 1
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   hit_valid,
   input  logic [WIX-1:0]         hit_way,
   input  logic                   fill_valid,
   input  logic [WIX-1:0]         fill_way,
   input  logic [TIER_W-1:0]      fill_tier,
   input  logic                   vic_req,
   input  logic [1:0]             mode,
   input  logic [WAYS*DIST_W-1:0] next_ref,
   output logic                   vic_valid,
   output logic [WIX-1:0]         vic_way
);
   localparam logic [RRPV_W-1:0] MAXV = '1;

   generate
      if (WAYS < 2) begin : g_bad_ways
         $error("WAYS must be at least 2");
      end
      if (RRPV_W < 2) begin : g_bad_rrpv
         $error("RRPV_W must be at least 2");
      end
   endgenerate

   logic [TIER_W-1:0] ins_tier;
   logic [RRPV_W-1:0] ins_rrpv;

   grrip_ins_map #(.NUM_BKT(NUM_BKT), .TIER_W(TIER_W), .RRPV_W(RRPV_W)) u_map (
      .tier_i (fill_tier),
      .tier_o (ins_tier),
      .rrpv_o (ins_rrpv)
   );

   logic [WAYS-1:0]             way_valid;
   logic [WAYS-1:0][RRPV_W-1:0] way_rrpv;
   logic [WAYS-1:0][TIER_W-1:0] way_tier;
   logic [WAYS-1:0][DIST_W-1:0] lane_dist;
   logic                        all_valid;
   logic [RRPV_W-1:0]           age_delta;
   logic [WIX-1:0]              pick;
   logic                        age_en;

   assign age_en = vic_req && all_valid;

   generate
      for (genvar g = 0; g < WAYS; g++) begin : g_way
         assign lane_dist[g] = next_ref[g*DIST_W +: DIST_W];
         grrip_way_slot #(.TIER_W(TIER_W), .RRPV_W(RRPV_W), .TOP(NUM_BKT-1)) u_slot (
            .clk       (clk),
            .rst_n     (rst_n),
            .fill_en   (fill_valid && !vic_req && fill_way == WIX'(g)),
            .fill_tier (ins_tier),
            .fill_rrpv (ins_rrpv),
            .hit_en    (hit_valid && !vic_req && hit_way == WIX'(g)),
            .age_en    (age_en),
            .age_delta (age_delta),
            .valid_o   (way_valid[g]),
            .rrpv_o    (way_rrpv[g]),
            .tier_o    (way_tier[g])
         );
      end
   endgenerate

   grrip_victim_sel #(.WAYS(WAYS), .TIER_W(TIER_W), .RRPV_W(RRPV_W), .DIST_W(DIST_W)) u_sel (
      .valid_i     (way_valid),
      .rrpv_i      (way_rrpv),
      .tier_i      (way_tier),
      .dist_i      (lane_dist),
      .mode_i      (grrip_mode_e'(mode)),
      .all_valid_o (all_valid),
      .age_delta_o (age_delta),
      .victim_o    (pick)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vic_valid <= 1'b0;
         vic_way   <= '0;
      end else begin
         vic_valid <= vic_req;
         if (vic_req) vic_way <= pick;
      end
   end

   p_req_gives_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
      vic_req |=> vic_valid);

   p_no_spurious_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !vic_req |=> !vic_valid);

   p_empty_first_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (vic_req && !(&way_valid)) |=> !way_valid[vic_way]);

   p_empty_no_age_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (vic_req && !(&way_valid)) |=> $stable(way_rrpv));

   p_victim_at_max_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (vic_req && (&way_valid)) |=> (way_rrpv[vic_way] == MAXV));

   p_req_blocks_fill_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (vic_req && !(&way_valid)) |=> $stable(way_valid));
endmodule

// File: tb/grrip_repl_bench.sv
`timescale 1ns/1ps
module grrip_repl_bench;
   localparam int WAYS = 16, RRPV_W = 3, NUM_BKT = 11, TIER_W = 4, DIST_W = 8;
   localparam int WIX = $clog2(WAYS);
   localparam int MAXV = (1 << RRPV_W) - 1;
   localparam int TOP = NUM_BKT - 1;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic hit_valid = 1'b0, fill_valid = 1'b0, vic_req = 1'b0;
   logic [WIX-1:0] hit_way = '0, fill_way = '0;
   logic [TIER_W-1:0] fill_tier = '0;
   logic [1:0] mode = '0;
   logic [WAYS*DIST_W-1:0] next_ref = '0;
   logic vic_valid;
   logic [WIX-1:0] vic_way;

   always #5 clk = ~clk;

   grrip_repl #(.WAYS(WAYS), .RRPV_W(RRPV_W), .NUM_BKT(NUM_BKT), .TIER_W(TIER_W), .DIST_W(DIST_W))
   u_grrip_repl (
      .clk(clk), .rst_n(rst_n), .hit_valid(hit_valid), .hit_way(hit_way),
      .fill_valid(fill_valid), .fill_way(fill_way), .fill_tier(fill_tier),
      .vic_req(vic_req), .mode(mode), .next_ref(next_ref),
      .vic_valid(vic_valid), .vic_way(vic_way)
   );

   int checks = 0, errors = 0;
   bit m_valid [WAYS];
   int m_rrpv [WAYS];
   int m_tier [WAYS];
   int m_dist [WAYS];

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic int start_rrpv(input int t);
      int tc = (t > TOP) ? TOP : t;
      return ((TOP - tc) * (MAXV - 1)) / TOP;
   endfunction

   function automatic bit [WAYS-1:0] f_cold(input bit [WAYS-1:0] m);
      int lo = 1 << 30;
      bit [WAYS-1:0] r = '0;
      for (int i = 0; i < WAYS; i++) if (m[i] && m_tier[i] < lo) lo = m_tier[i];
      for (int i = 0; i < WAYS; i++) r[i] = m[i] && m_tier[i] == lo;
      return r;
   endfunction

   function automatic bit [WAYS-1:0] f_far(input bit [WAYS-1:0] m);
      int hi = -1;
      bit [WAYS-1:0] r = '0;
      for (int i = 0; i < WAYS; i++) if (m[i] && m_dist[i] > hi) hi = m_dist[i];
      for (int i = 0; i < WAYS; i++) r[i] = m[i] && m_dist[i] == hi;
      return r;
   endfunction

   // Model of a victim request: returns the way and updates model state.
   function automatic int model_victim(input int md);
      int hi = 0;
      bit [WAYS-1:0] c = '0;
      for (int i = 0; i < WAYS; i++) if (!m_valid[i]) return i;
      for (int i = 0; i < WAYS; i++) if (m_rrpv[i] > hi) hi = m_rrpv[i];
      for (int i = 0; i < WAYS; i++) begin
         m_rrpv[i] += MAXV - hi;
         c[i] = (m_rrpv[i] == MAXV);
      end
      if (md == 1) c = f_cold(f_far(c));
      else if (md == 2) c = f_cold(c);
      else c = f_far(f_cold(c));
      for (int i = 0; i < WAYS; i++) if (c[i]) return i;
      return -1;
   endfunction

   function automatic string mode_req(input int md);
      if (md == 1) return "R8";
      if (md == 2) return "R9";
      return "R7";
   endfunction

   // One cycle of stimulus; victim checked in the cycle after the request.
   task automatic step(input bit hv, input int hw, input bit fv, input int fw, input int ft,
                       input bit vr, input int md, input string tag);
      int exp_way = 0;
      @(negedge clk);
      hit_valid = hv; hit_way = WIX'(hw);
      fill_valid = fv; fill_way = WIX'(fw); fill_tier = TIER_W'(ft);
      vic_req = vr; mode = 2'(md);
      for (int i = 0; i < WAYS; i++) next_ref[i*DIST_W +: DIST_W] = DIST_W'(m_dist[i]);
      @(posedge clk);
      if (vr) exp_way = model_victim(md);
      else begin
         if (hv && m_valid[hw] && !(fv && fw == hw)) begin
            if (m_tier[hw] == TOP) m_rrpv[hw] = 0;
            else if (m_rrpv[hw] > 0) m_rrpv[hw]--;
         end
         if (fv) begin
            m_valid[fw] = 1'b1;
            m_tier[fw] = (ft > TOP) ? TOP : ft;
            m_rrpv[fw] = start_rrpv(ft);
         end
      end
      @(negedge clk);
      hit_valid = 1'b0; fill_valid = 1'b0; vic_req = 1'b0;
      if (vr) begin
         check(vic_valid == 1'b1, "R2", int'(vic_valid), 1);
         check(int'(vic_way) == exp_way, tag, int'(vic_way), exp_way);
      end else begin
         check(vic_valid == 1'b0, "R2", int'(vic_valid), 0);
      end
   endtask

   task automatic fill(input int w, input int t);
      step(0, 0, 1, w, t, 0, 0, "R4");
   endtask

   // All ways hot, way 3 coldest tier (start 6), way 7 tier 1 (start 5), then way 3 hit to 5.
   task automatic setup_pair();
      for (int i = 0; i < WAYS; i++) fill(i, TOP);
      fill(3, 0);
      fill(7, 1);
      step(1, 3, 0, 0, 0, 0, 0, "R5");
   endtask

   initial begin
      for (int i = 0; i < WAYS; i++) begin
         m_valid[i] = 0; m_rrpv[i] = 0; m_tier[i] = 0; m_dist[i] = 0;
      end
      void'($urandom(32'd1234));
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      check(vic_valid == 1'b0, "R1", int'(vic_valid), 0);
      step(0, 0, 0, 0, 0, 1, 0, "R1");
      // Hole in the middle of a partly filled set
      for (int i = 0; i < WAYS; i++) if (i != 5) fill(i, i % NUM_BKT);
      step(0, 0, 0, 0, 0, 1, 0, "R3");
      // Hit on invalid way 5, then fill in the request cycle is dropped
      step(1, 5, 0, 0, 0, 0, 0, "R5");
      step(0, 0, 1, 5, 3, 1, 0, "R11");
      step(0, 0, 0, 0, 0, 1, 1, "R11");
      // Tier above range clamps to hottest
      fill(5, 15);
      // Coldest tier wins on insertion priority
      for (int i = 0; i < WAYS; i++) fill(i, TOP);
      fill(9, 0);
      step(0, 0, 0, 0, 0, 1, 0, "R4");
      // Mode ordering
      setup_pair();
      for (int i = 0; i < WAYS; i++) m_dist[i] = 0;
      m_dist[7] = 200; m_dist[3] = 10;
      step(0, 0, 0, 0, 0, 1, 0, "R7");
      setup_pair();
      step(0, 0, 0, 0, 0, 1, 1, "R8");
      setup_pair();
      step(0, 0, 0, 0, 0, 1, 2, "R9");
      setup_pair();
      step(0, 0, 0, 0, 0, 1, 3, "R7");
      // Aged values retained; non-hot hits step down
      setup_pair();
      step(0, 0, 0, 0, 0, 1, 0, "R6");
      step(1, 3, 0, 0, 0, 0, 0, "R5");
      step(1, 3, 0, 0, 0, 0, 0, "R5");
      step(0, 0, 0, 0, 0, 1, 0, "R6");
      // Equal distances, equal tiers: lowest index
      for (int i = 0; i < WAYS; i++) begin m_dist[i] = 4; fill(i, 2); end
      step(0, 0, 0, 0, 0, 1, 1, "R10");
      // Lane placement of the distance vector
      for (int i = 0; i < WAYS; i++) m_dist[i] = i;
      step(0, 0, 0, 0, 0, 1, 1, "R12");
      // Random mix
      for (int n = 0; n < 4000; n++) begin
         int op = int'($urandom_range(0, 9));
         int md = int'($urandom_range(0, 3));
         for (int i = 0; i < WAYS; i++) m_dist[i] = int'($urandom_range(0, 3));
         if (op < 3)
            step(0, 0, 0, 0, 0, 1, md, mode_req(md));
         else if (op < 4)
            step(1, int'($urandom_range(0, WAYS-1)), 1, int'($urandom_range(0, WAYS-1)),
                 int'($urandom_range(0, 12)), 1, md, "R11");
         else
            step(1, int'($urandom_range(0, WAYS-1)), op < 6, int'($urandom_range(0, WAYS-1)),
                 int'($urandom_range(6, 12)), 0, md, "R5");
      end
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #1500000;
      checks++;
      errors++;
      $display("FAIL watchdog R2 actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule